// File: doc/BRIEF.md
# Snooping Bus Host Response Collector

This block is the memory-controller end of a snooping bus shared by a small number of caching clients. Every coherent transaction that the broadcast stage copies to the clients is also presented to this host. A write-back updates the host's small word store at once. A read waits in the host until each client has posted its snoop result for that line.

From those snoop results the host makes one decision. If a client other than the requester reports that it owns the line, that client will copy the data to the requester. The host then supplies nothing and only absorbs the data that comes out on its ingest input, writing it into memory. Otherwise the host returns the memory word to the requester with a return mode. The mode is private when the requester may hold the line alone and shared when another client keeps a copy.

The controller has four states. **IDLE** accepts a transaction. **GATHER** collects the snoop results. **SUPPLY** drives the data return for one cycle. **INGEST** waits for the cache-to-cache data. The transitions are:
- IDLE→GATHER on a read.
- IDLE→IDLE on a write-back or reserved kind.
- GATHER→GATHER while any result is missing.
- GATHER→SUPPLY when all results are in and no other client owns the line.
- GATHER→INGEST when all results are in and another client owns the line.
- SUPPLY→IDLE always.
- INGEST→IDLE on an ingest beat.

Top module: `snp_host_collector`

## Requirements
- R1: After reset `txn_ready` is 1, `ret_valid` is 0 and every memory word reads back as 0.
- R2: A transaction of kind 2 (write-back) presented in IDLE is taken in that cycle. It writes `txn_val` to word `txn_addr`, produces no return, and leaves `txn_ready` at 1.
- R3: A read, kind 0 (shared read) or kind 1 (exclusive read), produces no return until every client has posted a snoop result. The first result from a client is kept and a repeated one is ignored. Snoop codes in `coh_code[2c+1:2c]` for client c are 0 miss, 1 shared, 2 owned and 3 treated as miss.
- R4: From the cycle after a read is accepted until the read completes, `txn_ready` is 0, so only one transaction is in flight.
- R5: If a client other than the requester reports code 2, no return is made. The host waits for `ingest_valid`, writes `ingest_data` to the read's address, and then returns to IDLE.
- R6: Otherwise `ret_valid` is high for exactly one cycle. It carries the memory word at the read's address on `ret_data` and the requester's index on `ret_dst`.
- R7: `ret_mode` is 1 (private) for kind 1. For kind 0 it is 1 when no other client reported code 1 and 0 (shared) when one did.
- R8: The requester's own snoop result never affects the outcome.
- R9: `ingest_valid` outside INGEST and snoop results outside GATHER are ignored.
- R10: Kind 3 is accepted and discarded: no memory change and no return.
- R11: `ret_valid` rises in the cycle right after the clock edge that captures the last missing snoop result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Broadcast transaction present |
| txn_ready | output | 1 | Host can take a transaction (IDLE) |
| txn_kind | input | 2 | 0 shared read, 1 exclusive read, 2 write-back, 3 reserved |
| txn_src | input | SW | Index of the issuing client |
| txn_val | input | DW | Write-back value |
| txn_addr | input | AW | Word address |
| coh_valid | input | NC | One snoop-result strobe per client |
| coh_code | input | 2*NC | Per-client snoop code |
| ingest_valid | input | 1 | Cache-to-cache data beat seen by the host |
| ingest_data | input | DW | Data being copied between clients |
| ret_valid | output | 1 | Host data return |
| ret_data | output | DW | Returned memory word |
| ret_mode | output | 1 | 1 private, 0 shared |
| ret_dst | output | SW | Requester index |

## Verification
The hardest case to reach is a read whose snoop results arrive split across cycles. In that case a client re-sends a different, conflicting code after its first one has been captured, and the captured result must win. The stimulus sweeps every pairing of requester code, other-client code, read kind, requester and address. It staggers the second result by zero to two cycles and re-pulses the first client with the owned bit flipped. This way, a design that waits too little, or that takes a late code, changes the return path or the mode.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        K_RD  = 2'd0,
        K_RDX = 2'd1,
        K_WB  = 2'd2,
        K_RSV = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        C_MISS = 2'd0,
        C_SHR  = 2'd1,
        C_OWN  = 2'd2,
        C_RSV  = 2'd3
    } coh_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_SUPPLY = 2'd2,
        ST_INGEST = 2'd3
    } st_e;

    localparam logic MODE_SHARED  = 1'b0;
    localparam logic MODE_PRIVATE = 1'b1;

endpackage

// File: rtl/snp_gather.sv
module snp_gather
    import snp_pkg::*;
#(
    parameter int NC = 2,
    parameter int SW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            en,
    input  logic [SW-1:0]   src,
    input  logic [NC-1:0]   coh_valid,
    input  logic [2*NC-1:0] coh_code,
    output logic            all_in,
    output logic            other_shr,
    output logic            other_own
);

    logic [NC-1:0] seen_now;
    logic [NC-1:0] shr_v;
    logic [NC-1:0] own_v;

    for (genvar i = 0; i < NC; i++) begin : g_cli
        localparam logic [SW-1:0] IDX = SW'(i);
        logic       seen_q;
        logic [1:0] code_q;
        logic [1:0] code_now;
        logic       is_other;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q <= 1'b0;
                code_q <= 2'd0;
            end else if (clear) begin
                seen_q <= 1'b0;
                code_q <= 2'd0;
            end else if (en && coh_valid[i] && !seen_q) begin
                seen_q <= 1'b1;
                code_q <= coh_code[2*i +: 2];
            end
        end

        always_comb begin
            seen_now[i] = seen_q | (en & coh_valid[i]);
            code_now    = seen_q ? code_q : coh_code[2*i +: 2];
            is_other    = (IDX != src);
            shr_v[i]    = is_other && seen_now[i] && (code_now == C_SHR);
            own_v[i]    = is_other && seen_now[i] && (code_now == C_OWN);
        end
    end

    assign all_in    = &seen_now;
    assign other_shr = |shr_v;
    assign other_own = |own_v;

endmodule

// File: rtl/snp_regfile.sv
module snp_regfile #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/snp_ctl.sv
module snp_ctl
    import snp_pkg::*;
#(
    parameter int SW = 1,
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_valid,
    input  logic [1:0]    txn_kind,
    input  logic [SW-1:0] txn_src,
    input  logic [DW-1:0] txn_val,
    input  logic [AW-1:0] txn_addr,
    input  logic          all_in,
    input  logic          other_shr,
    input  logic          other_own,
    input  logic          ingest_valid,
    input  logic [DW-1:0] ingest_data,
    output logic          txn_ready,
    output logic          gather_clear,
    output logic          gather_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          ret_valid,
    output logic          ret_mode,
    output logic [SW-1:0] ret_dst
);

    st_e           state;
    st_e           nxt;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] src_q;
    logic          excl_q;
    logic          priv_q;
    logic          is_read;

    assign is_read = (txn_kind == K_RD) || (txn_kind == K_RDX);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (txn_valid && is_read) nxt = ST_GATHER;
            end
            ST_GATHER: begin
                if (all_in) nxt = other_own ? ST_INGEST : ST_SUPPLY;
            end
            ST_SUPPLY: begin
                nxt = ST_IDLE;
            end
            ST_INGEST: begin
                if (ingest_valid) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            src_q  <= '0;
            excl_q <= 1'b0;
            priv_q <= MODE_PRIVATE;
        end else begin
            if (state == ST_IDLE && txn_valid && is_read) begin
                addr_q <= txn_addr;
                src_q  <= txn_src;
                excl_q <= (txn_kind == K_RDX);
            end
            if (state == ST_GATHER && all_in) begin
                priv_q <= excl_q || !other_shr;
            end
        end
    end

    always_comb begin
        txn_ready    = 1'b0;
        gather_clear = 1'b0;
        gather_en    = 1'b0;
        mem_we       = 1'b0;
        mem_waddr    = txn_addr;
        mem_wdata    = txn_val;
        mem_raddr    = addr_q;
        ret_valid    = 1'b0;
        ret_mode     = priv_q;
        ret_dst      = src_q;
        unique case (state)
            ST_IDLE: begin
                txn_ready    = 1'b1;
                gather_clear = 1'b1;
                mem_we       = txn_valid && (txn_kind == K_WB);
            end
            ST_GATHER: begin
                gather_en = 1'b1;
            end
            ST_SUPPLY: begin
                ret_valid = 1'b1;
            end
            ST_INGEST: begin
                mem_we    = ingest_valid;
                mem_waddr = addr_q;
                mem_wdata = ingest_data;
            end
            default: begin
                txn_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/snp_host_collector.sv
module snp_host_collector
    import snp_pkg::*;
#(
    parameter int  NC = 2,
    parameter int  DW = 8,
    parameter int  AW = 3,
    localparam int SW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            txn_valid,
    output logic            txn_ready,
    input  logic [1:0]      txn_kind,
    input  logic [SW-1:0]   txn_src,
    input  logic [DW-1:0]   txn_val,
    input  logic [AW-1:0]   txn_addr,
    input  logic [NC-1:0]   coh_valid,
    input  logic [2*NC-1:0] coh_code,
    input  logic            ingest_valid,
    input  logic [DW-1:0]   ingest_data,
    output logic            ret_valid,
    output logic [DW-1:0]   ret_data,
    output logic            ret_mode,
    output logic [SW-1:0]   ret_dst
);

    logic          all_in;
    logic          other_shr;
    logic          other_own;
    logic          gather_clear;
    logic          gather_en;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] mem_raddr;
    logic [SW-1:0] src_hold;

    snp_ctl #(.SW(SW), .DW(DW), .AW(AW)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_valid    (txn_valid),
        .txn_kind     (txn_kind),
        .txn_src      (txn_src),
        .txn_val      (txn_val),
        .txn_addr     (txn_addr),
        .all_in       (all_in),
        .other_shr    (other_shr),
        .other_own    (other_own),
        .ingest_valid (ingest_valid),
        .ingest_data  (ingest_data),
        .txn_ready    (txn_ready),
        .gather_clear (gather_clear),
        .gather_en    (gather_en),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .mem_raddr    (mem_raddr),
        .ret_valid    (ret_valid),
        .ret_mode     (ret_mode),
        .ret_dst      (src_hold)
    );

    snp_gather #(.NC(NC), .SW(SW)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (gather_clear),
        .en        (gather_en),
        .src       (src_hold),
        .coh_valid (coh_valid),
        .coh_code  (coh_code),
        .all_in    (all_in),
        .other_shr (other_shr),
        .other_own (other_own)
    );

    snp_regfile #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (ret_data)
    );

    assign ret_dst = src_hold;

endmodule

// File: rtl/snp_host_checker.sv
module snp_host_checker #(
    parameter int NC = 2,
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int SW = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            txn_valid,
    input logic            txn_ready,
    input logic [1:0]      txn_kind,
    input logic [SW-1:0]   txn_src,
    input logic [NC-1:0]   coh_valid,
    input logic            ret_valid,
    input logic            ret_mode,
    input logic [SW-1:0]   ret_dst
);

    logic [1:0]    kind_q;
    logic [SW-1:0] src_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= 2'd0;
            src_q  <= '0;
        end else if (txn_valid && txn_ready) begin
            kind_q <= txn_kind;
            src_q  <= txn_src;
        end
    end

    AST_RET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid); // R6

    AST_NO_RET_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        txn_ready |-> !ret_valid); // R6

    AST_READ_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && !txn_kind[1]) |=> !txn_ready); // R4

    AST_WB_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && txn_kind == 2'd2) |=> (txn_ready && !ret_valid)); // R2

    AST_RSV_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && txn_kind == 2'd3) |=> (txn_ready && !ret_valid)); // R10

    AST_EXCL_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && kind_q == 2'd1) |-> ret_mode); // R7

    AST_DST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_dst == src_q)); // R6

endmodule

bind snp_host_collector snp_host_checker #(.NC(NC), .DW(DW), .AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_kind  (txn_kind),
    .txn_src   (txn_src),
    .coh_valid (coh_valid),
    .ret_valid (ret_valid),
    .ret_mode  (ret_mode),
    .ret_dst   (ret_dst)
);

// File: tb/sim_snp_host_collector.sv
module sim_snp_host_collector;

    localparam int NC = 2;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int SW = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            txn_valid = 1'b0;
    logic            txn_ready;
    logic [1:0]      txn_kind = 2'd0;
    logic [SW-1:0]   txn_src = '0;
    logic [DW-1:0]   txn_val = '0;
    logic [AW-1:0]   txn_addr = '0;
    logic [NC-1:0]   coh_valid = '0;
    logic [2*NC-1:0] coh_code = '0;
    logic            ingest_valid = 1'b0;
    logic [DW-1:0]   ingest_data = '0;
    logic            ret_valid;
    logic [DW-1:0]   ret_data;
    logic            ret_mode;
    logic [SW-1:0]   ret_dst;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] exp_mem [8];

    always #4 clk = ~clk;

    snp_host_collector #(.NC(NC), .DW(DW), .AW(AW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_txn(input int kind, input int src, input int addr, input int val);
        txn_valid = 1'b1;
        txn_kind  = 2'(kind);
        txn_src   = SW'(src);
        txn_addr  = AW'(addr);
        txn_val   = DW'(val);
        step();
        txn_valid = 1'b0;
    endtask

    task automatic do_wb(input int addr, input int val);
        do_txn(2, 0, addr, val);
        exp_mem[addr] = DW'(val);
        chk(txn_ready == 1'b1 && ret_valid == 1'b0, "R2 wb idle", int'(txn_ready), 1);
    endtask

    // own_code goes to the requester, oth_code to the other client
    task automatic do_read(input int kind, input int src, input int addr,
                           input int own_code, input int oth_code, input int stagger);
        int oth;
        int first;
        int second;
        int fcode;
        int scode;
        bit owned;
        bit priv;
        oth   = 1 - src;
        owned = (oth_code == 2);
        priv  = (kind == 1) || (oth_code != 1);
        do_txn(kind, src, addr, 0);
        chk(txn_ready == 1'b0, "R4 busy after accept", int'(txn_ready), 0);
        if (stagger == 0) begin
            coh_valid = 2'b11;
            coh_code[2*src +: 2] = 2'(own_code);
            coh_code[2*oth +: 2] = 2'(oth_code);
            step();
            coh_valid = '0;
        end else begin
            first  = (stagger % 2 == 1) ? src : oth;
            second = 1 - first;
            fcode  = (first == src) ? own_code : oth_code;
            scode  = (second == src) ? own_code : oth_code;
            coh_valid = '0;
            coh_valid[first] = 1'b1;
            coh_code[2*first +: 2] = 2'(fcode);
            step();
            coh_valid = '0;
            for (int k = 0; k < stagger; k++) begin
                chk(ret_valid == 1'b0 && txn_ready == 1'b0, "R3 waits for all", int'(ret_valid), 0);
                step();
            end
            coh_valid = 2'b11;
            coh_code[2*first +: 2]  = 2'(fcode ^ 2);
            coh_code[2*second +: 2] = 2'(scode);
            step();
            coh_valid = '0;
        end
        if (owned) begin
            chk(ret_valid == 1'b0, "R5 no return when owned", int'(ret_valid), 0);
            step();
            chk(txn_ready == 1'b0, "R5 waits for ingest", int'(txn_ready), 0);
            ingest_valid = 1'b1;
            ingest_data  = DW'(~(addr * 29 + src));
            step();
            ingest_valid = 1'b0;
            exp_mem[addr] = DW'(~(addr * 29 + src));
            chk(txn_ready == 1'b1 && ret_valid == 1'b0, "R5 back to idle", int'(txn_ready), 1);
        end else begin
            chk(ret_valid == 1'b1, "R11 return timing", int'(ret_valid), 1);
            chk(ret_data == exp_mem[addr], "R6 data", int'(ret_data), int'(exp_mem[addr]));
            chk(ret_dst == SW'(src), "R6 dst", int'(ret_dst), src);
            chk(ret_mode == priv, "R7 R8 mode", int'(ret_mode), int'(priv));
            step();
            chk(ret_valid == 1'b0 && txn_ready == 1'b1, "R6 single pulse", int'(ret_valid), 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 8; a++) exp_mem[a] = '0;
        step();
        step();
        rst_n = 1'b1;
        step();
        chk(txn_ready == 1'b1, "R1 ready", int'(txn_ready), 1);
        chk(ret_valid == 1'b0, "R1 no return", int'(ret_valid), 0);
        for (int a = 0; a < 8; a++) begin
            do_read(0, 0, a, 0, 0, 0);
        end

        // main sweep
        for (int a = 0; a < 8; a++)
            for (int s = 0; s < 2; s++)
                for (int kd = 0; kd < 2; kd++)
                    for (int oc = 0; oc < 4; oc++)
                        for (int mc = 0; mc < 4; mc++) begin
                            do_wb(a, (a * 37 + s * 11 + kd * 5 + oc * 3 + mc) & 8'hFF);
                            do_read(kd, s, a, mc, oc, (a + oc + mc) % 3);
                        end

        // R9: ingest outside INGEST ignored
        do_wb(5, 8'h3C);
        do_read(0, 1, 5, 0, 0, 0);
        ingest_valid = 1'b1;
        ingest_data  = 8'hA5;
        step();
        ingest_valid = 1'b0;
        do_read(0, 0, 5, 0, 0, 0);
        chk(exp_mem[5] == 8'h3C, "R9 ingest idle", int'(exp_mem[5]), 8'h3C);

        // R9: snoop results in IDLE ignored
        coh_valid = 2'b11;
        coh_code  = 4'b0000;
        step();
        coh_valid = '0;
        do_txn(0, 0, 2, 0);
        step();
        chk(ret_valid == 1'b0 && txn_ready == 1'b0, "R9 idle snoop ignored", int'(ret_valid), 0);
        coh_valid = 2'b11;
        step();
        coh_valid = '0;
        chk(ret_valid == 1'b1 && ret_data == exp_mem[2], "R9 late response", int'(ret_data), int'(exp_mem[2]));
        step();

        // R10: reserved kind discarded
        do_wb(6, 8'h5A);
        do_txn(3, 1, 6, 8'hFF);
        chk(txn_ready == 1'b1 && ret_valid == 1'b0, "R10 discard", int'(ret_valid), 0);
        do_read(1, 1, 6, 2, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule